// File: doc/BRIEF.md
# Big-Endian Load/Store Alignment Unit

This block sits between a 32-bit core and a word-wide synchronous data memory. Each request carries a base register value, a signed 16-bit displacement, an access size, a signedness flag and a store/load direction. The block forms the effective address and places store data on the right byte lanes with matching byte enables. For loads, it takes the word the memory returns and extracts the addressed byte or halfword, extended to 32 bits.

Lanes are numbered big-endian. Byte offset 0 inside a word is the most significant byte, bits 31..24. The data width, displacement width and memory read latency are parameters.

Accesses that break size alignment are refused. The block raises a misalignment flag and drives no lane. A second-beat input adds one word to the address, so that a two-word transfer can be issued as two consecutive requests.

Top module: `lsu_align`

## Requirements
- R1: One cycle after a request, `acc_addr` equals `req_base` plus `req_offs` sign-extended to 32 bits, plus 4 when `req_beat2` is high.
- R2: Lanes are big-endian. `acc_be[i]` covers `acc_wdata[8i+7:8i]`, and byte offset o (the low two address bits) maps to lane 3-o. A byte access enables only `4'b1000 >> o`.
- R3: A byte load with `req_signed`=1 sign-extends the addressed byte to 32 bits. With `req_signed`=0 it zero-extends the byte.
- R4: A halfword access at offset 0 enables `4'b1100`, and at offset 2 it enables `4'b0011`. A halfword load returns bytes o and o+1, with byte o in bits 15..8, sign- or zero-extended according to `req_signed`.
- R5: A byte store writes bits 7..0 of `req_src` to the addressed byte. A halfword store writes bits 15..0 of `req_src`, high byte first. No other byte of memory changes.
- R6: A misaligned access drives `acc_misalign`=1 with `acc_be`=0 and `acc_en`=0. A halfword access is misaligned when address bit 0 is 1. A word access is misaligned when either low address bit is 1. Such an access writes nothing and produces no load result.
- R7: Size codes are byte=0, half=1 and word=2. Size code 3 is refused exactly like a misaligned access.
- R8: An aligned word access enables all four lanes. A word store places `req_src` unchanged, and a word load returns the memory word unchanged.
- R9: For an aligned load, `ld_valid` pulses for one cycle, RD_LAT+1 cycles after the access cycle, where RD_LAT is the memory read latency. It never pulses for stores, for refused accesses, or when idle.
- R10: During and right after reset, `acc_en`, `acc_we`, `acc_misalign`, `acc_be` and `ld_valid` are 0, and `ld_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 half, 2 word, 3 invalid |
| req_signed | input | 1 | Sign-extend load result |
| req_beat2 | input | 1 | Add one word to the address |
| req_base | input | 32 | Base register value |
| req_offs | input | 16 | Signed displacement |
| req_src | input | 32 | Store source register |
| mem_rdata | input | 32 | Word returned by memory RD_LAT cycles after the access |
| acc_en | output | 1 | Memory access strobe |
| acc_we | output | 1 | Write strobe |
| acc_addr | output | 32 | Effective address |
| acc_be | output | 4 | Byte enables, bit 3 = bits 31..24 |
| acc_wdata | output | 32 | Lane-positioned store data |
| acc_misalign | output | 1 | Request refused |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Extended load result |

## Verification
The bench goes after several lane and extension errors:

- **Lane mirroring.** Every byte and halfword offset is exercised in both signed and unsigned forms against memory words with the top bit of each byte set or clear. A design that mirrored the lane order (little-endian) would return the wrong byte and would corrupt a neighbouring byte on a store.
- **Extension direction.** An inverted extension would show as high bits that disagree with the expected value.
- **Store source half.** A store that took its byte from the top of the source register would show in the full memory comparison made after each store.

Every misaligned offset for halfword and word accesses, and the invalid size code, is sent as both a load and a store. The bench then checks that the enables stay quiet, that memory is unchanged and that no load result appears.

Second-beat requests and negative displacements across a word boundary catch an adder that drops the sign extension or the +4 step.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } acc_size_e;

endpackage

// File: rtl/lsu_ea_gen.sv
module lsu_ea_gen #(
  parameter int ADDR_W = 32,
  parameter int OFFS_W = 16,
  parameter int STEP   = 4
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [OFFS_W-1:0] offs,
  input  logic              beat2,
  output logic [ADDR_W-1:0] ea
);
  localparam int EXT_W = ADDR_W - OFFS_W;

  logic [ADDR_W-1:0] offs_x;
  logic [ADDR_W-1:0] step_v;

  assign offs_x = {{EXT_W{offs[OFFS_W-1]}}, offs};
  assign step_v = beat2 ? ADDR_W'(STEP) : '0;
  assign ea     = base + offs_x + step_v;
endmodule

// File: rtl/lsu_lane_steer.sv
module lsu_lane_steer
  import lsu_align_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int LW    = $clog2(LANES)
) (
  input  acc_size_e         size,
  input  logic [LW-1:0]     off,
  input  logic [DATA_W-1:0] src,
  output logic [LANES-1:0]  be,
  output logic [DATA_W-1:0] wdata,
  output logic              misalign
);
  always_comb begin
    case (size)
      SZ_BYTE: misalign = 1'b0;
      SZ_HALF: misalign = off[0];
      SZ_WORD: misalign = |off;
      default: misalign = 1'b1;
    endcase
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam logic [LW-1:0] POS = LW'(LANES - 1 - i);
    logic       hit;
    logic [7:0] byte_d;

    always_comb begin
      case (size)
        SZ_BYTE: begin
          hit    = (off == POS);
          byte_d = src[7:0];
        end
        SZ_HALF: begin
          hit    = (off[LW-1:1] == POS[LW-1:1]);
          byte_d = POS[0] ? src[7:0] : src[15:8];
        end
        default: begin
          hit    = 1'b1;
          byte_d = src[8*i +: 8];
        end
      endcase
    end

    assign be[i]            = hit & ~misalign;
    assign wdata[8*i +: 8]  = byte_d;
  end
endmodule

// File: rtl/lsu_load_pick.sv
module lsu_load_pick
  import lsu_align_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int LW    = $clog2(LANES)
) (
  input  logic [DATA_W-1:0] rdata,
  input  acc_size_e         size,
  input  logic [LW-1:0]     off,
  input  logic              sgn,
  output logic [DATA_W-1:0] data
);
  logic [DATA_W-1:0] sh_b;
  logic [DATA_W-1:0] sh_h;

  always_comb begin
    sh_b = rdata >> (8 * (LANES - 1 - int'(off)));
    sh_h = rdata >> (8 * (LANES - 2 - int'(off)));
    case (size)
      SZ_BYTE: data = {{(DATA_W-8){sgn & sh_b[7]}}, sh_b[7:0]};
      SZ_HALF: data = {{(DATA_W-16){sgn & sh_h[15]}}, sh_h[15:0]};
      default: data = rdata;
    endcase
  end
endmodule

// File: rtl/lsu_align.sv
module lsu_align
  import lsu_align_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int OFFS_W = 16,
  parameter int RD_LAT = 1,
  localparam int LANES = DATA_W / 8,
  localparam int LW    = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_store,
  input  logic [1:0]        req_size,
  input  logic              req_signed,
  input  logic              req_beat2,
  input  logic [ADDR_W-1:0] req_base,
  input  logic [OFFS_W-1:0] req_offs,
  input  logic [DATA_W-1:0] req_src,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              acc_en,
  output logic              acc_we,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [LANES-1:0]  acc_be,
  output logic [DATA_W-1:0] acc_wdata,
  output logic              acc_misalign,
  output logic              ld_valid,
  output logic [DATA_W-1:0] ld_data
);
  localparam int PIPE = RD_LAT + 1;

  logic [ADDR_W-1:0] ea;
  logic [LANES-1:0]  be_c;
  logic [DATA_W-1:0] wdata_c;
  logic              mis_c;
  logic [DATA_W-1:0] pick;
  acc_size_e         size_c;

  assign size_c = acc_size_e'(req_size);

  lsu_ea_gen #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W), .STEP(LANES)) u_ea (
    .base (req_base),
    .offs (req_offs),
    .beat2(req_beat2),
    .ea   (ea)
  );

  lsu_lane_steer #(.DATA_W(DATA_W)) u_steer (
    .size    (size_c),
    .off     (ea[LW-1:0]),
    .src     (req_src),
    .be      (be_c),
    .wdata   (wdata_c),
    .misalign(mis_c)
  );

  // load metadata travels alongside the memory read latency
  logic              m_ld   [PIPE];
  acc_size_e         m_size [PIPE];
  logic [LW-1:0]     m_off  [PIPE];
  logic              m_sgn  [PIPE];

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_en       <= 1'b0;
      acc_we       <= 1'b0;
      acc_misalign <= 1'b0;
      acc_be       <= '0;
      acc_addr     <= '0;
      acc_wdata    <= '0;
    end else begin
      acc_en       <= req_valid & ~mis_c;
      acc_we       <= req_valid & req_store & ~mis_c;
      acc_misalign <= req_valid & mis_c;
      acc_be       <= req_valid ? be_c : '0;
      if (req_valid) begin
        acc_addr  <= ea;
        acc_wdata <= wdata_c;
      end
    end
  end

  for (genvar s = 0; s < PIPE; s++) begin : g_meta
    always_ff @(posedge clk) begin
      if (rst) begin
        m_ld[s]   <= 1'b0;
        m_size[s] <= SZ_WORD;
        m_off[s]  <= '0;
        m_sgn[s]  <= 1'b0;
      end else if (s == 0) begin
        m_ld[s]   <= req_valid & ~req_store & ~mis_c;
        m_size[s] <= size_c;
        m_off[s]  <= ea[LW-1:0];
        m_sgn[s]  <= req_signed;
      end else begin
        m_ld[s]   <= m_ld[s-1];
        m_size[s] <= m_size[s-1];
        m_off[s]  <= m_off[s-1];
        m_sgn[s]  <= m_sgn[s-1];
      end
    end
  end

  lsu_load_pick #(.DATA_W(DATA_W)) u_pick (
    .rdata(mem_rdata),
    .size (m_size[PIPE-1]),
    .off  (m_off[PIPE-1]),
    .sgn  (m_sgn[PIPE-1]),
    .data (pick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_valid <= 1'b0;
      ld_data  <= '0;
    end else begin
      ld_valid <= m_ld[PIPE-1];
      if (m_ld[PIPE-1]) ld_data <= pick;
    end
  end
endmodule

// File: rtl/lsu_align_chk.sv
module lsu_align_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int OFFS_W = 16,
  parameter int RD_LAT = 1,
  localparam int LANES = DATA_W / 8
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_store,
  input logic [1:0]        req_size,
  input logic              req_beat2,
  input logic [ADDR_W-1:0] req_base,
  input logic [OFFS_W-1:0] req_offs,
  input logic              acc_en,
  input logic              acc_we,
  input logic [ADDR_W-1:0] acc_addr,
  input logic [LANES-1:0]  acc_be,
  input logic              acc_misalign,
  input logic              ld_valid
);
  assert_addr_R1: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> acc_addr == $past(req_base
      + {{(ADDR_W-OFFS_W){req_offs[OFFS_W-1]}}, req_offs}
      + (req_beat2 ? ADDR_W'(LANES) : ADDR_W'(0))));

  assert_byte_one_lane_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_size == 2'd0) |=> $countones(acc_be) == 1);

  assert_refused_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    acc_misalign |-> (acc_be == '0 && !acc_en && !acc_we));

  assert_bad_size_R7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_size == 2'd3) |=> acc_misalign);

  assert_word_lanes_R8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_size == 2'd2) |=> (acc_misalign || acc_be == '1));

  assert_ld_source_R9: assert property (@(posedge clk) disable iff (rst)
    ld_valid |-> $past(acc_en && !acc_we, RD_LAT + 1));

  assert_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!acc_en && !acc_misalign && acc_be == '0));

  initial assert_lanes_R2: assert (LANES == 4 || LANES == 8);
endmodule

bind lsu_align lsu_align_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFFS_W(OFFS_W), .RD_LAT(RD_LAT)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_valid   (req_valid),
  .req_store   (req_store),
  .req_size    (req_size),
  .req_beat2   (req_beat2),
  .req_base    (req_base),
  .req_offs    (req_offs),
  .acc_en      (acc_en),
  .acc_we      (acc_we),
  .acc_addr    (acc_addr),
  .acc_be      (acc_be),
  .acc_misalign(acc_misalign),
  .ld_valid    (ld_valid)
);

// File: tb/sim_lsu_align.sv
module sim_lsu_align;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_store, req_signed, req_beat2;
  logic [1:0]  req_size;
  logic [31:0] req_base, req_src, mem_rdata;
  logic [15:0] req_offs;
  logic        acc_en, acc_we, acc_misalign, ld_valid;
  logic [31:0] acc_addr, acc_wdata, ld_data;
  logic [3:0]  acc_be;

  int n_tests = 0;
  int n_fail  = 0;

  logic [7:0] mem     [256];
  logic [7:0] ref_mem [256];

  always #10 clk = ~clk;

  lsu_align u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_store(req_store),
    .req_size(req_size), .req_signed(req_signed), .req_beat2(req_beat2),
    .req_base(req_base), .req_offs(req_offs), .req_src(req_src),
    .mem_rdata(mem_rdata), .acc_en(acc_en), .acc_we(acc_we),
    .acc_addr(acc_addr), .acc_be(acc_be), .acc_wdata(acc_wdata),
    .acc_misalign(acc_misalign), .ld_valid(ld_valid), .ld_data(ld_data)
  );

  // word-wide synchronous memory, one-cycle read, lane i = bits 8i+7..8i
  always @(posedge clk) begin
    if (acc_en && acc_we) begin
      for (int i = 0; i < 4; i++)
        if (acc_be[i]) mem[{acc_addr[7:2], 2'b00} + 8'(3 - i)] <= acc_wdata[8*i +: 8];
    end
    if (acc_en && !acc_we)
      mem_rdata <= {mem[{acc_addr[7:2], 2'b00}], mem[{acc_addr[7:2], 2'b01}],
                    mem[{acc_addr[7:2], 2'b10}], mem[{acc_addr[7:2], 2'b11}]};
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic mem_compare(input string tag);
    int diffs = 0;
    for (int a = 0; a < 256; a++) if (mem[a] !== ref_mem[a]) diffs++;
    check(diffs == 0, tag, 32'(diffs), 32'd0);
  endtask

  task automatic access(input bit st, input logic [1:0] sz, input bit sg,
                        input bit b2, input logic [31:0] base,
                        input logic [15:0] offs, input logic [31:0] src,
                        input string tag);
    logic [31:0] ea, exp_d;
    logic [3:0]  exp_be;
    bit          bad;
    ea  = base + {{16{offs[15]}}, offs} + (b2 ? 32'd4 : 32'd0);
    bad = (sz == 2'd3) || (sz == 2'd1 && ea[0]) || (sz == 2'd2 && ea[1:0] != 2'd0);
    case (sz)
      2'd0:    exp_be = 4'b1000 >> ea[1:0];
      2'd1:    exp_be = 4'b1100 >> ea[1:0];
      default: exp_be = 4'b1111;
    endcase
    if (bad) exp_be = 4'b0000;
    case (sz)
      2'd0: exp_d = sg ? {{24{ref_mem[ea[7:0]][7]}}, ref_mem[ea[7:0]]}
                       : {24'd0, ref_mem[ea[7:0]]};
      2'd1: exp_d = sg ? {{16{ref_mem[ea[7:0]][7]}}, ref_mem[ea[7:0]], ref_mem[ea[7:0]+8'd1]}
                       : {16'd0, ref_mem[ea[7:0]], ref_mem[ea[7:0]+8'd1]};
      default: exp_d = {ref_mem[ea[7:0]], ref_mem[ea[7:0]+8'd1],
                        ref_mem[ea[7:0]+8'd2], ref_mem[ea[7:0]+8'd3]};
    endcase
    if (st && !bad) begin
      case (sz)
        2'd0: ref_mem[ea[7:0]] = src[7:0];
        2'd1: begin
          ref_mem[ea[7:0]]       = src[15:8];
          ref_mem[ea[7:0]+8'd1]  = src[7:0];
        end
        default: for (int k = 0; k < 4; k++) ref_mem[ea[7:0]+8'(k)] = src[31-8*k -: 8];
      endcase
    end
    @(negedge clk);
    req_valid = 1'b1; req_store = st; req_size = sz; req_signed = sg;
    req_beat2 = b2; req_base = base; req_offs = offs; req_src = src;
    @(negedge clk);
    req_valid = 1'b0;
    check(acc_addr == ea, {tag, " R1 addr"}, acc_addr, ea);
    check(acc_be == exp_be, {tag, " R2 be"}, {28'd0, acc_be}, {28'd0, exp_be});
    check(acc_misalign == bad && acc_en == !bad, {tag, " R6 refuse"},
          {30'd0, acc_misalign, acc_en}, {30'd0, bad, !bad});
    @(negedge clk);
    check(!ld_valid, {tag, " R9 early"}, {31'd0, ld_valid}, 32'd0);
    @(negedge clk);
    check(ld_valid == (!st && !bad), {tag, " R9 valid"}, {31'd0, ld_valid},
          {31'd0, !st && !bad});
    if (!st && !bad) check(ld_data == exp_d, {tag, " data"}, ld_data, exp_d);
    @(negedge clk);
    check(!ld_valid, {tag, " R9 pulse"}, {31'd0, ld_valid}, 32'd0);
    mem_compare({tag, " R5 mem"});
  endtask

  initial begin
    #(20ns * 100000);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] pat [4];
    pat[0] = 32'h80F17F01; pat[1] = 32'h7E82C3A4; pat[2] = 32'hFF00807F; pat[3] = 32'h01234567;
    for (int a = 0; a < 256; a++) begin mem[a] = 8'h00; ref_mem[a] = 8'h00; end
    mem_rdata = 32'd0;
    rst = 1'b1; req_valid = 1'b0; req_store = 1'b0; req_size = 2'd0;
    req_signed = 1'b0; req_beat2 = 1'b0; req_base = 32'd0; req_offs = 16'd0; req_src = 32'd0;
    repeat (3) @(negedge clk);
    check(!acc_en && !acc_we && !acc_misalign && acc_be == 4'd0 && !ld_valid && ld_data == 32'd0,
          "R10 reset", {acc_be, 28'd0} | ld_data, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check(!acc_en && !ld_valid, "R10 after reset", {30'd0, acc_en, ld_valid}, 32'd0);

    // R8 word stores fill memory, R1 with positive offsets
    for (int w = 0; w < 4; w++)
      access(1'b1, 2'd2, 1'b0, 1'b0, 32'h40, 16'(4 * w), pat[w], "R8 wstore");
    for (int w = 0; w < 4; w++)
      access(1'b0, 2'd2, 1'b0, 1'b0, 32'h40, 16'(4 * w), 32'd0, "R8 wload");

    // R3 byte loads every offset, both signedness
    for (int w = 0; w < 4; w++)
      for (int o = 0; o < 4; o++)
        for (int s = 0; s < 2; s++)
          access(1'b0, 2'd0, s[0], 1'b0, 32'h40 + 32'(4 * w), 16'(o), 32'd0, "R3 bload");

    // R4 halfword loads at both aligned offsets
    for (int w = 0; w < 4; w++)
      for (int o = 0; o < 4; o += 2)
        for (int s = 0; s < 2; s++)
          access(1'b0, 2'd1, s[0], 1'b0, 32'h40 + 32'(4 * w), 16'(o), 32'd0, "R4 hload");

    // R5 byte and half stores, source high bits must be ignored
    for (int o = 0; o < 4; o++)
      access(1'b1, 2'd0, 1'b0, 1'b0, 32'h80, 16'(o), 32'hDEADBE00 | 32'(o + 8'h90), "R5 bstore");
    access(1'b0, 2'd2, 1'b0, 1'b0, 32'h80, 16'd0, 32'd0, "R5 bstore readback");
    for (int o = 0; o < 4; o += 2)
      access(1'b1, 2'd1, 1'b0, 1'b0, 32'h84, 16'(o), 32'hCAFE0000 | 32'(16'h8A5C + o), "R5 hstore");
    access(1'b0, 2'd2, 1'b0, 1'b0, 32'h84, 16'd0, 32'd0, "R5 hstore readback");

    // R6 every misaligned offset, load and store
    for (int st = 0; st < 2; st++) begin
      for (int o = 1; o < 4; o += 2)
        access(st[0], 2'd1, 1'b1, 1'b0, 32'h44, 16'(o), 32'hFFFFFFFF, "R6 half");
      for (int o = 1; o < 4; o++)
        access(st[0], 2'd2, 1'b0, 1'b0, 32'h44, 16'(o), 32'hFFFFFFFF, "R6 word");
      access(st[0], 2'd3, 1'b0, 1'b0, 32'h48, 16'd0, 32'hFFFFFFFF, "R7 badsize");
    end

    // R1 second beat and negative offsets
    access(1'b1, 2'd2, 1'b0, 1'b0, 32'h90, 16'hFFF0, 32'h11223344, "R1 neg store");
    access(1'b1, 2'd2, 1'b0, 1'b1, 32'h90, 16'hFFF0, 32'h55667788, "R1 beat2 store");
    access(1'b0, 2'd2, 1'b0, 1'b1, 32'h7C, 16'h0004, 32'd0, "R1 beat2 load");
    access(1'b0, 2'd0, 1'b1, 1'b0, 32'h83, 16'hFFFE, 32'd0, "R1 neg byte");
    access(1'b0, 2'd1, 1'b1, 1'b1, 32'h7E, 16'hFFFC, 32'd0, "R1 beat2 half");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule